// File: doc/BRIEF.md
# Serial Break Wake and Inactivity Power Controller

This block decides whether one node of an isolated serial daisy chain is asleep or awake. While asleep it watches the receive line. A space (low level) that lasts long enough counts as a wake request. The node then wakes and regenerates an outgoing break of fixed length, so the next node in the chain is woken in turn. When that break ends, the block raises a one-cycle request to send the "awake" announcement.

Once awake, every valid received byte restarts an inactivity timer. When the timer runs out, the node goes back to sleep. A second, shorter timer tracks balancing. A balance refresh arms it, and balancing is dropped if no new refresh arrives in time. All time is counted in cycles where the millisecond tick is high. The UART sits outside this block and supplies only the byte-valid strobe. A byte that had a framing error never raises that strobe.

Top module: `wake_power_ctl`

## Requirements
- R1: After reset the node is asleep: awake, sendAwake, balActive and balExpired are 0, and txOut equals txData.
- R2: While asleep, rxLine held low across WAKE_MS (default 60) consecutive ticks wakes the node. awake rises at the clock edge that carries the 60th tick.
- R3: While asleep, an rxLine high level clears the low-time count, so a low that ends before WAKE_MS ticks leaves the node asleep. A new low then counts from zero. The count saturates.
- R4: From the wake edge, txOut is held at 0 regardless of txData until BREAK_MS (default 80) further ticks have passed.
- R5: At the edge of the BREAK_MS-th break tick, sendAwake is 1 for exactly one cycle and txOut follows txData again.
- R6: After the break, a byteValid restarts the idle count. The node sleeps at the edge of the IDLE_MS-th (default 5000) tick with no byteValid. If byteValid and a tick arrive in the same cycle, byteValid wins.
- R7: While awake, balRefresh sets balActive and restarts the balance count. At the edge of the BAL_MS-th (default 3000) tick after the last refresh, balActive falls and balExpired is 1 for one cycle.
- R8: Going to sleep clears awake and balActive at the same edge, with no balExpired pulse.
- R9: While asleep, byteValid and balRefresh have no effect: balActive stays 0 and the node stays asleep.
- R10: While awake, rxLine is ignored. A long low does not restart the outgoing break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msTick | input | 1 | Each cycle this is high counts as one millisecond |
| rxLine | input | 1 | Receive line level, 0 = space |
| byteValid | input | 1 | Strobe from UART for a byte received without framing error |
| balRefresh | input | 1 | Balance command received strobe |
| txData | input | 1 | Normal transmit line from the UART |
| txOut | output | 1 | Transmit line to the downstream node |
| awake | output | 1 | Node is awake (break or running) |
| sendAwake | output | 1 | One-cycle request to send the awake announcement |
| balActive | output | 1 | Balancing is permitted |
| balExpired | output | 1 | One-cycle pulse when balancing times out |

## Verification
The assertions assume that msTick, byteValid and balRefresh are synchronous to clk and that each cycle with msTick high is meant as one millisecond. They also assume byteValid is never raised for a framing-error byte, so a held break cannot look like traffic. The stimulus drives every input at the falling clock edge. It sends ticks as runs of cycles and raises byteValid only as separate single-cycle strobes. Random gaps and low lengths are drawn within the ranges that each requirement bounds.

// File: rtl/wake_ctl_pkg.sv
package wake_ctl_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_BREAK = 2'd1,
    ST_AWAKE = 2'd2
  } pwrState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic live;     // node is not asleep
    logic inBreak;  // outgoing break is being driven
    logic goSleep;  // this edge returns the node to sleep
  } ctlStrobe_t;

  // datapath -> control terminal-count events
  typedef struct packed {
    logic wakeHit;
    logic breakDone;
    logic idleDone;
  } dpEvent_t;

endpackage

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_ctl_pkg::*;
#(
  parameter int WAKE_MS  = 60,
  parameter int BREAK_MS = 80,
  parameter int IDLE_MS  = 5000,
  parameter int BAL_MS   = 3000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       msTick,
  input  logic       rxLine,
  input  logic       byteValid,
  input  logic       balRefresh,
  input  logic       txData,
  input  ctlStrobe_t ctl,
  output dpEvent_t   evt,
  output logic       txOut,
  output logic       balActive,
  output logic       balExpired
);

  localparam int RXW = $clog2(WAKE_MS + 1);
  localparam int BKW = $clog2(BREAK_MS);
  localparam int IDW = $clog2(IDLE_MS);
  localparam int BLW = $clog2(BAL_MS);

  logic [RXW-1:0] rxLowCnt;
  logic [BKW-1:0] brkCnt;
  logic [IDW-1:0] idleCnt;
  logic [BLW-1:0] balCnt;

  // low-time counter on the receive line, only while asleep
  always_ff @(posedge clk) begin
    if (!rstN || ctl.live || rxLine) begin
      rxLowCnt <= '0;
    end else if (msTick && rxLowCnt != RXW'(WAKE_MS)) begin
      rxLowCnt <= rxLowCnt + 1'b1;
    end
  end

  // outgoing break length
  always_ff @(posedge clk) begin
    if (!rstN || !ctl.inBreak) begin
      brkCnt <= '0;
    end else if (msTick) begin
      brkCnt <= brkCnt + 1'b1;
    end
  end

  // inactivity timer, runs only after the break
  always_ff @(posedge clk) begin
    if (!rstN || !ctl.live || ctl.inBreak || byteValid) begin
      idleCnt <= '0;
    end else if (msTick) begin
      idleCnt <= idleCnt + 1'b1;
    end
  end

  // balance hold timer
  always_ff @(posedge clk) begin
    if (!rstN || !ctl.live || ctl.goSleep) begin
      balActive  <= 1'b0;
      balCnt     <= '0;
      balExpired <= 1'b0;
    end else if (balRefresh) begin
      balActive  <= 1'b1;
      balCnt     <= '0;
      balExpired <= 1'b0;
    end else if (balActive && msTick) begin
      if (balCnt == BLW'(BAL_MS - 1)) begin
        balActive  <= 1'b0;
        balCnt     <= '0;
        balExpired <= 1'b1;
      end else begin
        balCnt     <= balCnt + 1'b1;
        balExpired <= 1'b0;
      end
    end else begin
      balExpired <= 1'b0;
    end
  end

  always_comb begin
    evt.wakeHit   = !ctl.live && !rxLine && msTick && rxLowCnt == RXW'(WAKE_MS - 1);
    evt.breakDone = ctl.inBreak && msTick && brkCnt == BKW'(BREAK_MS - 1);
    evt.idleDone  = ctl.live && !ctl.inBreak && msTick && !byteValid
                    && idleCnt == IDW'(IDLE_MS - 1);
  end

  assign txOut = ctl.inBreak ? 1'b0 : txData;

  assert_rx_cnt_sat_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxLowCnt <= RXW'(WAKE_MS));

  assert_exp_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    balExpired |=> !balExpired);

  assert_exp_drops_bal_R7: assert property (@(posedge clk) disable iff (!rstN)
    balExpired |-> !balActive);

endmodule

// File: rtl/wake_control.sv
module wake_control
  import wake_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpEvent_t   evt,
  output ctlStrobe_t ctl,
  output logic       awake,
  output logic       sendAwake
);

  pwrState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_SLEEP: if (evt.wakeHit)   stateNext = ST_BREAK;
      ST_BREAK: if (evt.breakDone) stateNext = ST_AWAKE;
      ST_AWAKE: if (evt.idleDone)  stateNext = ST_SLEEP;
      default:                     stateNext = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_SLEEP;
      sendAwake <= 1'b0;
    end else begin
      state     <= stateNext;
      sendAwake <= (state == ST_BREAK) && evt.breakDone;
    end
  end

  always_comb begin
    ctl.live    = state != ST_SLEEP;
    ctl.inBreak = state == ST_BREAK;
    ctl.goSleep = state == ST_AWAKE && evt.idleDone;
  end

  assign awake = ctl.live;

  assert_announce_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    sendAwake |=> !sendAwake);

  assert_announce_after_break_R5: assert property (@(posedge clk) disable iff (!rstN)
    sendAwake |-> (state == ST_AWAKE && $past(state) == ST_BREAK));

endmodule

// File: rtl/wake_power_ctl.sv
module wake_power_ctl
  import wake_ctl_pkg::*;
#(
  parameter int WAKE_MS  = 60,
  parameter int BREAK_MS = 80,
  parameter int IDLE_MS  = 5000,
  parameter int BAL_MS   = 3000
) (
  input  logic clk,
  input  logic rstN,
  input  logic msTick,
  input  logic rxLine,
  input  logic byteValid,
  input  logic balRefresh,
  input  logic txData,
  output logic txOut,
  output logic awake,
  output logic sendAwake,
  output logic balActive,
  output logic balExpired
);

  ctlStrobe_t ctl;
  dpEvent_t   evt;

  wake_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .evt       (evt),
    .ctl       (ctl),
    .awake     (awake),
    .sendAwake (sendAwake)
  );

  wake_datapath #(
    .WAKE_MS  (WAKE_MS),
    .BREAK_MS (BREAK_MS),
    .IDLE_MS  (IDLE_MS),
    .BAL_MS   (BAL_MS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .msTick     (msTick),
    .rxLine     (rxLine),
    .byteValid  (byteValid),
    .balRefresh (balRefresh),
    .txData     (txData),
    .ctl        (ctl),
    .evt        (evt),
    .txOut      (txOut),
    .balActive  (balActive),
    .balExpired (balExpired)
  );

  assert_wake_drives_break_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(awake) |-> !txOut);

  assert_asleep_no_bal_R8: assert property (@(posedge clk) disable iff (!rstN)
    !awake |-> !balActive);

endmodule

// File: tb/wake_power_ctl_test.sv
module wake_power_ctl_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msTick = 1'b0, rxLine = 1'b1, byteValid = 1'b0, balRefresh = 1'b0, txData = 1'b1;
  logic txOut, awake, sendAwake, balActive, balExpired;
  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  wake_power_ctl uut (
    .clk(clk), .rstN(rstN), .msTick(msTick), .rxLine(rxLine),
    .byteValid(byteValid), .balRefresh(balRefresh), .txData(txData),
    .txOut(txOut), .awake(awake), .sendAwake(sendAwake),
    .balActive(balActive), .balExpired(balExpired)
  );

  function automatic logic expWake(int lowTicks);
    return lowTicks >= 60;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) begin
      msTick = 1'b1;
      @(posedge clk); @(negedge clk);
      msTick = 1'b0;
    end
  endtask

  task automatic idleCyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic sendByte();
    byteValid = 1'b1; idleCyc(); byteValid = 1'b0;
  endtask

  task automatic refresh();
    balRefresh = 1'b1; idleCyc(); balRefresh = 1'b0;
  endtask

  task automatic doWake();
    rxLine = 1'b0; tick(60); rxLine = 1'b1; tick(80);
    chk("R5 announce", sendAwake, 1'b1);
    idleCyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idleCyc();
    // R1 reset state
    chk("R1 awake", awake, 1'b0);
    chk("R1 txOut", txOut, 1'b1);
    chk("R1 sendAwake", sendAwake, 1'b0);
    chk("R1 balActive", balActive, 1'b0);
    chk("R1 balExpired", balExpired, 1'b0);

    // R3 short lows do not wake, and the count restarts
    for (int i = 0; i < 5; i++) begin
      int k;
      k = $urandom_range(1, 59);
      rxLine = 1'b0; tick(k); rxLine = 1'b1; tick(1);
      chk("R3 short low", awake, expWake(k));
    end
    rxLine = 1'b0; tick(30); rxLine = 1'b1; tick(1);
    rxLine = 1'b0; tick(59);
    chk("R3 count restarted", awake, expWake(59));
    rxLine = 1'b1; tick(1);

    // R9 traffic while asleep is ignored
    sendByte(); refresh(); tick(3);
    chk("R9 balActive asleep", balActive, 1'b0);
    chk("R9 awake asleep", awake, 1'b0);

    // R2 wake on 60th tick
    rxLine = 1'b0; tick(59);
    chk("R2 not yet", awake, 1'b0);
    tick(1);
    chk("R2 woke", awake, 1'b1);
    chk("R4 break at wake", txOut, 1'b0);
    txData = 1'b1; idleCyc();
    chk("R4 txData blocked", txOut, 1'b0);
    tick(79);
    chk("R4 break held", txOut, 1'b0);
    chk("R5 no early announce", sendAwake, 1'b0);
    tick(1);
    chk("R5 announce", sendAwake, 1'b1);
    chk("R5 tx restored", txOut, 1'b1);
    idleCyc();
    chk("R5 single pulse", sendAwake, 1'b0);
    // R10 rx still low, no new break
    tick(100);
    chk("R10 no rebreak", txOut, 1'b1);
    chk("R10 awake", awake, 1'b1);
    rxLine = 1'b1;

    // R6 random traffic keeps node awake
    sendByte();
    for (int i = 0; i < 5; i++) begin
      tick($urandom_range(100, 4999));
      chk("R6 kept awake", awake, 1'b1);
      sendByte();
    end
    tick(4999);
    byteValid = 1'b1; msTick = 1'b1; idleCyc();
    byteValid = 1'b0; msTick = 1'b0;
    chk("R6 byte beats tick", awake, 1'b1);
    tick(4999);
    chk("R6 before timeout", awake, 1'b1);
    tick(1);
    chk("R6 slept", awake, 1'b0);
    txData = 1'b0; idleCyc();
    chk("R6 tx follows asleep", txOut, 1'b0);
    txData = 1'b1;

    // R7 balance expiry with refresh
    doWake();
    sendByte();
    refresh();
    chk("R7 armed", balActive, 1'b1);
    tick(1500);
    refresh();
    tick(2999);
    chk("R7 still active", balActive, 1'b1);
    chk("R7 no early pulse", balExpired, 1'b0);
    tick(1);
    chk("R7 dropped", balActive, 1'b0);
    chk("R7 pulse", balExpired, 1'b1);
    idleCyc();
    chk("R7 pulse single", balExpired, 1'b0);

    // R8 sleep clears balance without pulse
    sendByte();
    tick(2500);
    refresh();
    tick(2499);
    chk("R8 active before sleep", balActive, 1'b1);
    chk("R8 awake before sleep", awake, 1'b1);
    tick(1);
    chk("R8 asleep", awake, 1'b0);
    chk("R8 bal cleared", balActive, 1'b0);
    chk("R8 no expiry pulse", balExpired, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule